// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor's load/store port and a slower memory that moves whole four-word blocks. Each line holds a valid flag, an address tag and four 32-bit words, all kept in plain registers. A load that finds its line present returns the word in the same cycle with no stall. A load that misses stalls the processor. It then fetches the entire block from memory into the line and finishes as a hit.

Every store goes to memory as well as to the cache, and the processor waits until memory takes the write. A store whose line is absent first brings the whole block in, then merges its word into the line and sends the write out. The processor must hold its request, direction, address and write data steady while stall is high. An access completes at the clock edge that ends a cycle in which stall is low.

The memory port carries a request with a direction flag and an address, and the request is held until memory answers with ready. For a block read, the address is the block's base. For a write, it is the word's address. Refill words come back later on a valid strobe, each tagged with its word position.

Top module: `dmc_cache`

## Requirements
- R1: The byte address is split, from the top down, into a tag of 28-IDX_W bits, an index of IDX_W bits (default 6), a word select in bits [3:2] and a byte offset in bits [1:0]. The byte offset has no effect on which word a load returns.
- R2: Reset clears every valid flag. The first access to any address after reset is a miss, including an address whose tag and index are all zero.
- R3: A load whose line is valid with an equal stored tag returns the selected word with stall low in the same cycle and issues no memory request.
- R4: A load miss raises stall in the cycle it is seen. It then issues one read request (mem_we=0) whose address is the block base (low four bits zero), holds the request and address steady until ready, and completes with the word taken from memory.
- R5: Refill words must arrive with word positions 0, 1, 2, 3 in that order. The line's tag and valid flag are written only with word 3, so a line is not usable until its fill ends.
- R6: Every store issues exactly one write request (mem_we=1) carrying the word-aligned address and the store data. Stall stays high until the cycle in which ready is seen, and the cached word takes the new value.
- R7: A store miss first refills the whole block with one read request and then writes through. Afterwards the stored word reads back with the new value and the line's other words read back with memory's values.
- R8: An access to a different tag at the same index replaces the line, so the earlier block misses again on its next use.
- R9: Stall is low whenever no request is present, and high on every cycle from the detection of a miss or a store until the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the access completes |
| cpu_stall | output | 1 | Processor must hold its access |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | 1 = word write, 0 = block read |
| mem_addr | output | 32 | Block base (read) or word address (write) |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Refill word strobe |
| mem_rword | input | 2 | Position of the refill word in its block |
| mem_rdata | input | 32 | Refill word data |

## Verification
The bench first loads tag zero at index zero straight after reset. A cache that left valid flags set or held stale tags would answer this load from the array. It then loads a neighbour word inside a just-filled block, which must hit, and swaps two tags on one index, where a design that ignored the tag would return the wrong block. A store that misses is read back at the stored word and at a sibling word. A design that skipped allocation or merged in the wrong order would show memory's old value or lose the store. Stores run against a memory that delays ready, so any early release of stall shows up as a missing or duplicated write. The bench also reloads a line after a write-through to show that memory received the data, and repeats a hit after a second reset to catch valid flags that outlive reset.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 32;
  localparam int BLK_WRDS = 4;
  localparam int WSEL_W   = 2;
  localparam int LOW_W    = 4;   // word select + byte offset

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FREQ  = 2'd1,
    ST_FWAIT = 2'd2,
    ST_WR    = 2'd3
  } dmc_state_e;

  // Base byte address of the block holding a.
  function automatic logic [ADDR_W-1:0] blk_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
  endfunction

  // Word-aligned byte address of a.
  function automatic logic [ADDR_W-1:0] word_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  // Word position of a inside its block.
  function automatic logic [WSEL_W-1:0] word_sel(input logic [ADDR_W-1:0] a);
    return a[LOW_W-1:2];
  endfunction

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             inv_en,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (inv_en) valid_q[wr_idx] <= 1'b0;
      if (wr_en)  valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];

  AST_INV_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_en && wr_en)); // R5

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int IDX_W  = 6,
  parameter int WSEL_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = (1 << IDX_W) * (1 << WSEL_W);

  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[{wr_idx, wr_word}] <= wr_data;
  end

  assign rd_data = word_q[{rd_idx, rd_word}];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_we,
  input  logic       line_hit,
  input  logic       mem_ready,
  input  logic       mem_rvalid,
  input  logic [1:0] mem_rword,
  output dmc_state_e state_q,
  output logic       cpu_stall,
  output logic       mem_req,
  output logic       mem_we,
  output logic       fill_we,
  output logic       fill_last,
  output logic       store_we,
  output logic       line_inv
);
  dmc_state_e state_d;
  logic [1:0] fill_cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (!line_hit)   state_d = ST_FREQ;
          else if (cpu_we) state_d = ST_WR;
        end
      end
      ST_FREQ:  if (mem_ready) state_d = ST_FWAIT;
      ST_FWAIT: if (fill_last) state_d = ST_IDLE;
      ST_WR:    if (mem_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fill_cnt_q <= 2'd0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FREQ)  fill_cnt_q <= 2'd0;
      else if (fill_we)        fill_cnt_q <= fill_cnt_q + 2'd1;
    end
  end

  assign fill_we   = (state_q == ST_FWAIT) && mem_rvalid;
  assign fill_last = fill_we && (fill_cnt_q == 2'd3);
  assign line_inv  = (state_q == ST_FREQ) && mem_ready;
  assign store_we  = (state_q == ST_WR) && mem_ready;
  assign mem_req   = (state_q == ST_FREQ) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);

  always_comb begin
    unique case (state_q)
      ST_IDLE:  cpu_stall = cpu_req && (cpu_we || !line_hit);
      ST_WR:    cpu_stall = !mem_ready;
      default:  cpu_stall = 1'b1;
    endcase
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req); // R4
  AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> mem_rword == fill_cnt_q); // R5
  AST_STORE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_ready |-> cpu_stall); // R6

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_stall,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic        mem_rvalid,
  input  logic [1:0]  mem_rword,
  input  logic [31:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - LOW_W - IDX_W;

  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  logic [WSEL_W-1:0] a_word;
  logic [TAG_W-1:0]  line_tag;
  logic              line_valid;
  logic              line_hit;
  dmc_state_e        state;
  logic              fill_we, fill_last, store_we, line_inv;
  logic              dat_we;
  logic [WSEL_W-1:0] dat_word;
  logic [31:0]       dat_wdata;

  assign a_idx  = cpu_addr[IDX_W+LOW_W-1:LOW_W];
  assign a_tag  = cpu_addr[ADDR_W-1:IDX_W+LOW_W];
  assign a_word = word_sel(cpu_addr);

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(a_idx), .rd_tag(line_tag), .rd_valid(line_valid),
    .inv_en(line_inv), .wr_en(fill_last), .wr_idx(a_idx), .wr_tag(a_tag)
  );

  assign line_hit = line_valid && (line_tag == a_tag);

  dmc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .line_hit(line_hit),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rword(mem_rword),
    .state_q(state), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we),
    .fill_we(fill_we), .fill_last(fill_last),
    .store_we(store_we), .line_inv(line_inv)
  );

  assign dat_we    = fill_we || store_we;
  assign dat_word  = fill_we ? mem_rword : a_word;
  assign dat_wdata = fill_we ? mem_rdata : cpu_wdata;

  dmc_data_store #(.IDX_W(IDX_W), .WSEL_W(WSEL_W), .DATA_W(WORD_W)) u_data (
    .clk(clk),
    .rd_idx(a_idx), .rd_word(a_word), .rd_data(cpu_rdata),
    .wr_en(dat_we), .wr_idx(a_idx), .wr_word(dat_word), .wr_data(dat_wdata)
  );

  assign mem_addr  = mem_we ? word_base(cpu_addr) : blk_base(cpu_addr);
  assign mem_wdata = cpu_wdata;

  AST_MEMADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> $stable(mem_addr)); // R4
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_we && !cpu_stall |-> !mem_req); // R3
  AST_TAG_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |-> mem_rvalid && mem_rword == 2'd3); // R5
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !cpu_stall); // R9
  AST_VALID_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> line_hit && state == ST_IDLE); // R4
  AST_READ_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr[3:0] == 4'h0); // R1

endmodule

// File: tb/dmc_cache_test.sv
`timescale 1ns/1ps
module dmc_cache_test;
  localparam int IDX_W = 6;
  localparam int SHIFT = IDX_W + 4;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [1:0]  mem_rword = '0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  dmc_cache #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rword(mem_rword),
    .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [31:0] mk(input logic [31:0] t, input logic [31:0] i,
                                     input logic [31:0] w);
    return (t << SHIFT) | (i << 4) | (w << 2);
  endfunction

  function automatic logic [31:0] init_word(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  // ---------------- memory model ----------------
  logic [31:0] mstore [logic [31:0]];
  logic [31:0] shadow [logic [31:0]];
  int rd_cnt = 0, wr_cnt = 0, wait_cnt = 0;
  logic [31:0] last_waddr = '0, last_wdata = '0, b_addr = '0;
  logic        b_on = 1'b0, gap = 1'b0;
  logic [1:0]  b_beat = '0;

  function automatic logic [31:0] model_word(input logic [31:0] a);
    if (mstore.exists(a)) return mstore[a];
    return init_word(a);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0; mem_rvalid <= 1'b0; b_on <= 1'b0; wait_cnt <= 0;
    end else begin
      if (mem_req && mem_ready) begin
        mem_ready <= 1'b0;
        wait_cnt  <= 0;
        if (mem_we) begin
          mstore[mem_addr] = mem_wdata;
          wr_cnt <= wr_cnt + 1; last_waddr <= mem_addr; last_wdata <= mem_wdata;
        end else begin
          rd_cnt <= rd_cnt + 1; b_on <= 1'b1; b_addr <= mem_addr;
          b_beat <= 2'd0; gap <= 1'b1;
        end
      end else if (mem_req && !b_on) begin
        if (wait_cnt == LAT) mem_ready <= 1'b1;
        else wait_cnt <= wait_cnt + 1;
      end
      if (b_on) begin
        if (gap) begin
          mem_rvalid <= 1'b0; gap <= 1'b0;
        end else begin
          mem_rvalid <= 1'b1; mem_rword <= b_beat;
          mem_rdata  <= model_word(b_addr + {28'd0, b_beat, 2'b00});
          b_beat <= b_beat + 2'd1;
          gap <= ~b_beat[0];
          if (b_beat == 2'd3) b_on <= 1'b0;
        end
      end else begin
        mem_rvalid <= 1'b0;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(input logic [31:0] a);
    if (shadow.exists(a)) return shadow[a];
    return init_word(a);
  endfunction

  int last_sc;

  task automatic run_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic exp_hit, input string tag);
    int r0, w0, sc;
    logic first;
    logic [31:0] wa;
    wa = {a[31:2], 2'b00};
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    r0 = rd_cnt; w0 = wr_cnt;
    #1;
    first = cpu_stall;
    sc = 0;
    while (cpu_stall) begin
      @(negedge clk); #1; sc++;
    end
    if (!we) begin
      check(first == !exp_hit, {tag, " R3/R4 stall on detection"}, {31'd0, first}, {31'd0, !exp_hit});
      check(cpu_rdata == ref_word(wa), {tag, " R3/R4 load data"}, cpu_rdata, ref_word(wa));
    end else begin
      check(first == 1'b1, {tag, " R9 store stalls"}, {31'd0, first}, 32'd1);
    end
    @(posedge clk); #1;
    cpu_req = 1'b0;
    check((rd_cnt - r0) == (exp_hit ? 0 : 1), {tag, " R8/R7 block reads"},
          rd_cnt - r0, exp_hit ? 0 : 1);
    if (we) begin
      shadow[wa] = d;
      check((wr_cnt - w0) == 1, {tag, " R6 one write"}, wr_cnt - w0, 1);
      check(last_waddr == wa, {tag, " R6 write address"}, last_waddr, wa);
      check(last_wdata == d, {tag, " R6 write data"}, last_wdata, d);
    end else begin
      check((wr_cnt - w0) == 0, {tag, " R3 no write on load"}, wr_cnt - w0, 0);
    end
    last_sc = sc;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        hit;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, mk(0, 0, 0), 32'h0, 1'b0},            // R2 tag 0 index 0 after reset
    '{1'b0, mk(1, 3, 0), 32'h0, 1'b0},            // R4 miss
    '{1'b0, mk(1, 3, 2), 32'h0, 1'b1},            // R3 neighbour word hit
    '{1'b0, mk(2, 3, 1), 32'h0, 1'b0},            // R8 conflict
    '{1'b0, mk(1, 3, 0), 32'h0, 1'b0},            // R8 evicted block misses
    '{1'b1, mk(1, 3, 1), 32'hAAAA_0001, 1'b1},    // R6 store hit
    '{1'b0, mk(1, 3, 1), 32'h0, 1'b1},            // R6 cached word updated
    '{1'b1, mk(5, 7, 2), 32'h5555_1234, 1'b0},    // R7 store miss
    '{1'b0, mk(5, 7, 2), 32'h0, 1'b1},            // R7 merged word
    '{1'b0, mk(5, 7, 3), 32'h0, 1'b1},            // R7 sibling from memory
    '{1'b0, mk(2, 3, 1), 32'h0, 1'b0},            // R8 swap back
    '{1'b0, mk(1, 3, 1), 32'h0, 1'b0},            // R6 memory got the write
    '{1'b0, mk(32'h3F_FFFF, 63, 3), 32'h0, 1'b0}, // R1 top tag, top index
    '{1'b0, mk(32'h3F_FFFF, 63, 0), 32'h0, 1'b1}, // R1 same block
    '{1'b0, mk(5, 7, 3) | 32'd2, 32'h0, 1'b1}     // R1 byte offset ignored
  };

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 / R2 reset state
    check(cpu_stall == 1'b0, "R9 no stall after reset", {31'd0, cpu_stall}, 0);
    check(mem_req == 1'b0, "R2 no memory request after reset", {31'd0, mem_req}, 0);
    repeat (3) @(negedge clk);
    check(cpu_stall == 1'b0 && mem_req == 1'b0, "R9 idle stays quiet",
          {30'd0, cpu_stall, mem_req}, 0);

    for (int k = 0; k < NV; k++) begin
      run_op(VEC[k].we, VEC[k].addr, VEC[k].wdata, VEC[k].hit,
             $sformatf("vec%0d", k));
      if (!VEC[k].we && VEC[k].hit)
        check(last_sc == 0, "R3 hit takes no stall", last_sc, 0);
    end

    // R6: store hit waits for the delayed ready
    run_op(1'b1, mk(5, 7, 0), 32'hDEAD_0BAD, 1'b1, "r6_slow");
    check(last_sc >= LAT + 1, "R6 stall covers ready delay", last_sc, LAT + 1);
    // R4: miss stall covers request wait plus four beats
    run_op(1'b0, mk(9, 20, 1), 32'h0, 1'b0, "r4_len");
    check(last_sc >= LAT + 5, "R4 stall covers refill", last_sc, LAT + 5);

    // R2: reset again, a previously cached line must miss
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    run_op(1'b0, mk(5, 7, 2), 32'h0, 1'b0, "r2_rereset");
    run_op(1'b0, mk(5, 7, 2), 32'h0, 1'b1, "r2_refilled");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule